// File: doc/BRIEF.md
# Limit-Match Counter Timer

This block is a memory-mapped counter/timer with a 32-bit register interface. A single-cycle enable input, `tick_en`, is pulsed at a fixed rate (one pulse every 500 ns in the intended system). Each pulse advances a count field that sits in bits 30..9 of the counter word. Because the tick comes in as an enable, the block can run from any system clock.

The count is compared against a programmable limit. On the tick that would bring the count up to a nonzero limit, the count goes back to zero and counting carries on, so the timer is periodic. On that same edge a sticky reached flag is set and a level interrupt is raised. Reading the limit register acknowledges both. A limit of zero turns the block into a free-running counter that never matches.

Software reaches the block through one read strobe and one write strobe on word addresses. There are two ways to load the limit. One restarts the count from zero. The other leaves the running count alone.

Top module: `tick_limit_timer`

## Requirements
- R1: After reset the limit is zero, the count is zero, the reached flag is clear, `irq` is low and the counter runs in free-run mode.
- R2: Each cycle with `tick_en` high advances the count field (bits 30..9 of the counter word) by one unit of bit 9. A cycle without `tick_en` leaves the count unchanged. Bits 8..0 of the counter word always read as zero.
- R3: A read of word 1 returns the reached flag in bit 31 and the count in bits 30..9, with all other bits zero. The read does not clear the flag or the interrupt.
- R4: A write to word 0 loads the limit as `wr_data & 32'h7FFF_FE00`, restarts the count from zero and deasserts `irq`. It leaves the reached flag as it was. If a tick falls on the same edge, the write wins and no match is taken on that edge.
- R5: A read of word 0 returns the limit in bits 30..9, with all other bits zero. As a side effect it clears both the reached flag and `irq`. If a match occurs on the same edge, the match wins and both stay set.
- R6: With a nonzero limit, consider the tick on which the count plus one would equal the limit field. On that edge the count returns to zero, and the reached flag and `irq` are both set. The sequence then repeats with the same period.
- R7: A write to word 2 loads the limit with the same masking as R4. It leaves the running count, the flag and `irq` untouched.
- R8: With a zero limit the counter runs freely. The tick that would bring the count word to 0x7FFF_FE00 wraps the count to zero instead. The flag and `irq` are never set in this mode.
- R9: Writes to word 1 and to words 3 through 7 change no state. Reads of words 3 through 7 return zero.
- R10: With the default registered read path, `rd_data` shows the addressed word in the cycle after the `rd_en` edge. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count enable, pulsed at the fixed tick rate |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access; side effects take place on this edge |
| addr | input | 3 | Word address of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt, high from a match until it is acknowledged |

## Verification
All results are due one clock edge after their stimulus:
- The count, the flag and `irq` change on the edge that samples `tick_en` or a strobe.
- `rd_data` is loaded on the edge that samples `rd_en`. It therefore reflects the state as it stood before that edge's own side effects.

The bench drives every input at a falling edge and holds it for exactly one rising edge. It then samples at the next falling edge, so each check looks at the value produced by exactly one register stage. The two collision cases put both stimuli into the same single cycle and inspect the result one cycle later. Those cases are a restarting write against a tick (R4) and a limit read against a match (R5).

// File: rtl/tlt_pkg.sv
package tlt_pkg;

   // Word-level register selection decoded from the access address.
   typedef enum logic [1:0] {
      SEL_LIMIT      = 2'd0,   // limit, restart on write, acknowledge on read
      SEL_COUNT      = 2'd1,   // count and flag, read-only
      SEL_LIMIT_KEEP = 2'd2,   // limit, count kept on write
      SEL_NONE       = 2'd3    // any undefined word
   } reg_sel_e;

   localparam int unsigned WORD_LIMIT      = 0;
   localparam int unsigned WORD_COUNT      = 1;
   localparam int unsigned WORD_LIMIT_KEEP = 2;

   function automatic reg_sel_e decode_word(input int unsigned w);
      reg_sel_e s;
      case (w)
         WORD_LIMIT:      s = SEL_LIMIT;
         WORD_COUNT:      s = SEL_COUNT;
         WORD_LIMIT_KEEP: s = SEL_LIMIT_KEEP;
         default:         s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/tlt_tick_counter.sv
// Count field with limit compare; a zero limit selects the all-ones terminal.
module tlt_tick_counter #(
   parameter int CW = 22
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          restart,
   input  logic [CW-1:0] limit_units,
   output logic [CW-1:0] count_q,
   output logic          match
);

   initial assert (CW >= 2) else $error("tlt_tick_counter: CW must be at least 2");

   logic [CW-1:0] nxt;
   logic [CW-1:0] term;
   logic          lim_zero;
   logic          hit;

   assign nxt      = count_q + 1'b1;
   assign lim_zero = (limit_units == '0);
   assign term     = lim_zero ? '1 : limit_units;
   assign hit      = tick_en && (nxt == term);
   assign match    = hit && !lim_zero && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n)       count_q <= '0;
      else if (restart) count_q <= '0;
      else if (tick_en) count_q <= hit ? '0 : nxt;
   end

   // R2: no tick and no restart keeps the count
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !restart) |=> $stable(count_q));

   // R4: restarting write clears the count
   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (count_q == '0));

   // R6: a match leaves the count at zero
   p_match_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> (count_q == '0));

   // R8: the all-ones terminal value is never held
   p_never_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
      count_q != '1);

endmodule

// File: rtl/tlt_event_flags.sv
// Sticky reached flag and level interrupt; a set outranks any clear.
module tlt_event_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic ack_read,
   input  logic irq_drop,
   output logic reached_q,
   output logic irq_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reached_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         if (set_evt)       reached_q <= 1'b1;
         else if (ack_read) reached_q <= 1'b0;

         if (set_evt)                   irq_q <= 1'b1;
         else if (ack_read || irq_drop) irq_q <= 1'b0;
      end
   end

   // R6: a match sets both flag and interrupt
   p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> (reached_q && irq_q));

   // R5: acknowledge without a competing match clears both
   p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_read && !set_evt) |=> (!reached_q && !irq_q));

   // R4: dropping the interrupt leaves the flag as it was
   p_drop_keeps_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_drop && !ack_read && !set_evt) |=> (reached_q == $past(reached_q)));

   // R6: the interrupt is never high without the flag
   p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> reached_q);

endmodule

// File: rtl/tick_limit_timer.sv
module tick_limit_timer #(
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 3,
   parameter int CNT_LSB       = 9,
   parameter int CNT_MSB       = 30,
   parameter bit RD_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   import tlt_pkg::*;

   localparam int CW = CNT_MSB - CNT_LSB + 1;

   initial begin
      assert (CNT_LSB >= 1) else $error("tick_limit_timer: CNT_LSB must leave zero low bits");
      assert (CNT_MSB > CNT_LSB) else $error("tick_limit_timer: CNT_MSB must exceed CNT_LSB");
      assert (CNT_MSB < DATA_W - 1) else $error("tick_limit_timer: top data bit is reserved for the flag");
      assert (ADDR_W >= 2) else $error("tick_limit_timer: ADDR_W must cover three words");
   end

   reg_sel_e          sel;
   logic [CW-1:0]     limit_units;
   logic [CW-1:0]     count_q;
   logic              match;
   logic              reached_q;
   logic              irq_q;
   logic              wr_limit_rst;
   logic              wr_limit_keep;
   logic              ack_read;
   logic [DATA_W-1:0] rd_word;
   logic              unused_wr_bits;

   assign sel           = decode_word(32'(addr));
   assign wr_limit_rst  = wr_en && (sel == SEL_LIMIT);
   assign wr_limit_keep = wr_en && (sel == SEL_LIMIT_KEEP);
   assign ack_read      = rd_en && (sel == SEL_LIMIT);
   assign unused_wr_bits = ^{wr_data[DATA_W-1:CNT_MSB+1], wr_data[CNT_LSB-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n)                              limit_units <= '0;
      else if (wr_limit_rst || wr_limit_keep)  limit_units <= wr_data[CNT_MSB:CNT_LSB];
   end

   tlt_tick_counter #(.CW(CW)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .restart     (wr_limit_rst),
      .limit_units (limit_units),
      .count_q     (count_q),
      .match       (match)
   );

   tlt_event_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_evt   (match),
      .ack_read  (ack_read),
      .irq_drop  (wr_limit_rst),
      .reached_q (reached_q),
      .irq_q     (irq_q)
   );

   assign irq = irq_q;

   always_comb begin
      rd_word = '0;
      case (sel)
         SEL_LIMIT: rd_word[CNT_MSB:CNT_LSB] = limit_units;
         SEL_COUNT: begin
            rd_word[CNT_MSB:CNT_LSB] = count_q;
            rd_word[DATA_W-1]        = reached_q;
         end
         default:   rd_word = '0;
      endcase
   end

   generate
      if (RD_REGISTERED) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= rd_word;
         end
         assign rd_data = rd_q;

         // R2: low bits of a counter read are zero
         p_rd_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && sel == SEL_COUNT) |=> (rd_data[CNT_LSB-1:0] == '0));

         // R9: undefined words read as zero
         p_rd_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && sel == SEL_NONE) |=> (rd_data == '0));

         // R10: read data holds between reads
         p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> $stable(rd_data));
      end else begin : g_rd_comb
         assign rd_data = rd_en ? rd_word : '0;
      end
   endgenerate

   // R8: with a zero limit the flag stays clear
   p_freerun_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (limit_units == '0 && !reached_q) |=> !reached_q);

   // R7: no-restart limit write keeps the count
   p_keep_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_limit_keep && !tick_en) |=> $stable(count_q));

   // R9: writes to undefined or read-only words touch nothing
   p_ignore_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (sel == SEL_NONE || sel == SEL_COUNT) && !tick_en && !rd_en)
         |=> ($stable(limit_units) && $stable(count_q) && $stable(irq_q)));

endmodule

// File: tb/sim_tick_limit_timer.sv
`timescale 1ns/1ps
module sim_tick_limit_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [31:0] d;

   always #10 clk = ~clk;

   tick_limit_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [31:0] v);
      @(negedge clk); wr_en = 1'b1; addr = a; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; v = rd_data;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 irq after reset", {31'b0, irq}, 32'd0);
      bus_rd(3'd0, v); chk("R1 limit after reset", v, 32'h0);
      bus_rd(3'd1, v); chk("R1 count after reset", v, 32'h0);
   endtask

   task automatic t_count;
      logic [31:0] v;
      ticks(5);
      bus_rd(3'd1, v); chk("R2 count after 5 ticks", v, 32'h0000_0A00);
      repeat (3) @(negedge clk);
      bus_rd(3'd1, v); chk("R2 no tick no change", v, 32'h0000_0A00);
   endtask

   task automatic t_limit_mask;
      logic [31:0] v;
      bus_wr(3'd0, 32'hFFFF_FFFF);
      bus_rd(3'd0, v); chk("R4 limit masked", v, 32'h7FFF_FE00);
      bus_rd(3'd1, v); chk("R4 count restarted", v, 32'h0);
   endtask

   task automatic t_match;
      logic [31:0] v;
      bus_wr(3'd0, 32'h0000_07FF);
      bus_rd(3'd0, v); chk("R5 limit readback", v, 32'h0000_0600);
      ticks(2);
      chk("R6 no irq before match", {31'b0, irq}, 32'd0);
      bus_rd(3'd1, v); chk("R6 count before match", v, 32'h0000_0400);
      ticks(1);
      chk("R6 irq on match", {31'b0, irq}, 32'd1);
      bus_rd(3'd1, v); chk("R6 flag set, count zero", v, 32'h8000_0000);
      bus_rd(3'd1, v); chk("R3 counter read keeps flag", v, 32'h8000_0000);
      chk("R3 counter read keeps irq", {31'b0, irq}, 32'd1);
      bus_rd(3'd0, v); chk("R5 ack read data", v, 32'h0000_0600);
      chk("R5 irq cleared", {31'b0, irq}, 32'd0);
      bus_rd(3'd1, v); chk("R5 flag cleared", v, 32'h0);
      ticks(3);
      chk("R6 periodic irq", {31'b0, irq}, 32'd1);
   endtask

   task automatic t_write_drops_irq;
      logic [31:0] v;
      bus_wr(3'd0, 32'h0000_0600);
      chk("R4 write drops irq", {31'b0, irq}, 32'd0);
      bus_rd(3'd1, v); chk("R4 write keeps flag", v, 32'h8000_0000);
      bus_rd(3'd0, v);
   endtask

   task automatic t_keep_count;
      logic [31:0] v;
      bus_wr(3'd0, 32'h0000_1400);
      ticks(4);
      bus_wr(3'd2, 32'h0000_0C00);
      bus_rd(3'd1, v); chk("R7 count kept", v, 32'h0000_0800);
      bus_rd(3'd0, v); chk("R7 new limit", v, 32'h0000_0C00);
      ticks(1);
      chk("R7 no early match", {31'b0, irq}, 32'd0);
      ticks(1);
      chk("R7 match at new limit", {31'b0, irq}, 32'd1);
      bus_rd(3'd0, v);
   endtask

   task automatic t_collide_write;
      logic [31:0] v;
      bus_wr(3'd0, 32'h0000_1400);
      ticks(2);
      @(negedge clk); wr_en = 1'b1; addr = 3'd0; wr_data = 32'h0000_1400; tick_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
      bus_rd(3'd1, v); chk("R4 write beats tick", v, 32'h0);
   endtask

   task automatic t_freerun;
      logic [31:0] v;
      bus_wr(3'd0, 32'h0);
      bus_rd(3'd0, v); chk("R8 zero limit readback", v, 32'h0);
      ticks(20);
      chk("R8 no irq in free-run", {31'b0, irq}, 32'd0);
      bus_rd(3'd1, v); chk("R8 free-run count, no flag", v, 32'h0000_2800);
   endtask

   task automatic t_undefined;
      logic [31:0] v;
      bus_wr(3'd1, 32'h1234_5600);
      bus_wr(3'd3, 32'hFFFF_FFFF);
      bus_wr(3'd7, 32'hFFFF_FFFF);
      bus_rd(3'd1, v); chk("R9 count untouched", v, 32'h0000_2800);
      bus_rd(3'd0, v); chk("R9 limit untouched", v, 32'h0);
      bus_rd(3'd3, v); chk("R9 word 3 reads zero", v, 32'h0);
      bus_rd(3'd5, v); chk("R9 word 5 reads zero", v, 32'h0);
   endtask

   task automatic t_rd_timing;
      logic [31:0] v;
      bus_rd(3'd1, v); chk("R10 read data", v, 32'h0000_2800);
      ticks(2);
      chk("R10 read data holds", rd_data, 32'h0000_2800);
   endtask

   task automatic t_collide_ack;
      logic [31:0] v;
      bus_wr(3'd0, 32'h0000_0200);
      ticks(1);
      chk("R6 limit one matches every tick", {31'b0, irq}, 32'd1);
      @(negedge clk); rd_en = 1'b1; addr = 3'd0; tick_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; tick_en = 1'b0;
      chk("R5 ack read data in collision", rd_data, 32'h0000_0200);
      chk("R5 match beats ack (irq)", {31'b0, irq}, 32'd1);
      bus_rd(3'd1, v); chk("R5 match beats ack (flag)", v, 32'h8000_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_limit_mask();
      t_match();
      t_write_drops_irq();
      t_keep_count();
      t_collide_write();
      t_freerun();
      t_undefined();
      t_rd_timing();
      t_collide_ack();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule